// File: doc/BRIEF.md
# Strobed Byte-Wide Latched I/O Port

This block is a byte-wide port that sits on a microprocessor bus. A data latch captures the input byte. A mode input chooses what clocks the latch. When mode is high, the port's own device-select term clocks it and the output is always driven. When mode is low, an external strobe clocks it and the output is driven only while the port is selected. The latch is level sensitive. While its clock is high, the output follows the live input. When the clock falls, the last value is held. An active-low clear empties the latch, but only while the latch clock is low.

A falling strobe edge raises a service request. Selecting the port, or the clear input, removes that request. The active-low interrupt output is asserted while a request is pending and also while the port is selected. The three-state output is modelled as a data bus together with a separate output-enable. Every control input (both selects, mode, strobe and clear) passes through a synchronizer on the system clock. An input change therefore takes effect two clock edges after it is sampled. The data input is used directly.

Top module: `strobed_io_port`

## Requirements
- R1: The port is selected only when `sel_a_ni` is 0 and `sel_b_i` is 1. Any control input change that is driven before clock edge k takes effect in the outputs after edge k+1.
- R2: With mode high, `data_oe_o` is 1 and the latch clock equals the select term.
- R3: With mode low, `data_oe_o` equals the select term and the latch clock equals the strobe.
- R4: While the latch clock is high, `data_o` equals `data_i` and the latch loads `data_i` every cycle. While it is low, `data_o` shows the held value, which does not change unless a clear applies.
- R5: A low clear zeroes the latch only while the latch clock is low. While the latch clock is high, the clear has no effect.
- R6: A 1-to-0 strobe transition sets a pending request. `irq_no` goes low after the third clock edge that follows the input fall.
- R7: A select or a low clear removes the pending request. If either one coincides with a strobe fall, the clear wins and no request remains.
- R8: `irq_no` is 0 exactly when a request is pending or the port is selected.
- R9: During reset and after it, the latch is zero, no request is pending, `irq_no` is 1 and `data_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_a_ni | input | 1 | Select input, active low |
| sel_b_i | input | 1 | Select input, active high |
| mode_i | input | 1 | Latch clock source and output-enable mode |
| stb_i | input | 1 | Strobe: latch clock in mode low, falling edge raises request |
| clr_ni | input | 1 | Active-low latch and request clear |
| data_i | input | DATA_W | Input byte |
| data_o | output | DATA_W | Latched or live byte |
| data_oe_o | output | 1 | Output enable; 0 stands for high impedance |
| irq_no | output | 1 | Interrupt, active low |

## Verification
The bench builds the port with its default parameters: an 8-bit data path and a 2-stage synchronizer. This gives the three-edge request latency and the two-edge control latency that the requirements state. With only eight data bits, random bytes soon repeat patterns and reach the all-ones and all-zeros values. Random toggling of strobe, selects, mode and clear exercises both latch clock sources. It also produces clears during transparent and during opaque phases, and select pulses that overlap strobe falls.

// File: rtl/io_port_pkg.sv
package io_port_pkg;
  typedef struct packed {
    logic sel_a_n;
    logic sel_b;
    logic mode;
    logic stb;
    logic clr_n;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  localparam ctrl_t CTRL_IDLE = '{sel_a_n: 1'b1, sel_b: 1'b0, mode: 1'b0,
                                  stb: 1'b0, clr_n: 1'b1};
endpackage

// File: rtl/io_sync.sv
module io_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= RST_VAL;
        else         stg_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= RST_VAL;
        else         stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/io_data_latch.sv
module io_data_latch #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         lc_i,
  input  logic         clr_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] y_o
);
  logic [W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hold_q <= '0;
    else if (lc_i)    hold_q <= d_i;
    else if (!clr_ni) hold_q <= '0;
  end

  assign y_o = lc_i ? d_i : hold_q;

  AST_LOAD_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lc_i |=> hold_q == $past(d_i)); // R4
  AST_HOLD_SHUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lc_i && clr_ni) |=> $stable(hold_q)); // R4
  AST_CLR_SHUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lc_i && !clr_ni) |=> hold_q == '0); // R5
endmodule

// File: rtl/io_srq.sv
module io_srq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  input  logic sel_i,
  input  logic clr_ni,
  output logic pend_o
);
  logic stb_d_q;
  logic fall;
  logic drop;
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stb_d_q <= 1'b0;
    else         stb_d_q <= stb_i;
  end

  assign fall = stb_d_q & ~stb_i;
  assign drop = sel_i | ~clr_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pend_q <= 1'b0;
    else if (drop) pend_q <= 1'b0;
    else if (fall) pend_q <= 1'b1;
  end

  assign pend_o = pend_q;

  AST_FALL_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(stb_i) && sel_i == 1'b0 && clr_ni) |=> pend_o); // R6
  AST_DROP_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i || !clr_ni) |=> !pend_o); // R7
  AST_NO_SPUR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_o) |-> $past(stb_d_q) && !$past(stb_i)); // R6
endmodule

// File: rtl/strobed_io_port.sv
module strobed_io_port
  import io_port_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_a_ni,
  input  logic              sel_b_i,
  input  logic              mode_i,
  input  logic              stb_i,
  input  logic              clr_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              irq_no
);
  ctrl_t ctrl_raw;
  ctrl_t ctrl_s;
  logic  sel_s;
  logic  lc;
  logic  pend;

  assign ctrl_raw = '{sel_a_n: sel_a_ni, sel_b: sel_b_i, mode: mode_i,
                      stb: stb_i, clr_n: clr_ni};

  io_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTRL_IDLE)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (ctrl_raw),
    .q_o    (ctrl_s)
  );

  assign sel_s = ~ctrl_s.sel_a_n & ctrl_s.sel_b;
  assign lc    = ctrl_s.mode ? sel_s : ctrl_s.stb;

  io_data_latch #(.W(DATA_W)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lc_i   (lc),
    .clr_ni (ctrl_s.clr_n),
    .d_i    (data_i),
    .y_o    (data_o)
  );

  io_srq u_srq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stb_i  (ctrl_s.stb),
    .sel_i  (sel_s),
    .clr_ni (ctrl_s.clr_n),
    .pend_o (pend)
  );

  assign data_oe_o = ctrl_s.mode | sel_s;
  assign irq_no    = ~(pend | sel_s);

  AST_OE_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_s.mode |-> data_oe_o); // R2
  AST_IRQ_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_s |-> !irq_no); // R8
  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend && !sel_s) |-> irq_no); // R8
  AST_RST_IRQ: assert property (@(posedge clk_i)
    !rst_ni |-> irq_no && !data_oe_o); // R9
endmodule

// File: tb/strobed_io_port_test.sv
`timescale 1ns/1ps
module strobed_io_port_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sel_a_n = 1'b1, sel_b = 1'b0, mode = 1'b0, stb = 1'b0, clr_n = 1'b1;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout;
  logic         oe, irq_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  strobed_io_port #(.DATA_W(W), .SYNC_STAGES(2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sel_a_ni(sel_a_n), .sel_b_i(sel_b),
    .mode_i(mode), .stb_i(stb), .clr_ni(clr_n), .data_i(din),
    .data_o(dout), .data_oe_o(oe), .irq_no(irq_n)
  );

  // reference: two-edge control delay, then the port rules
  logic [4:0]   m1, m2;
  logic         m_stb_d, m_pend;
  logic [W-1:0] m_hold;

  function automatic logic f_sel(input logic [4:0] c);
    return !c[4] && c[3];
  endfunction
  function automatic logic f_lc(input logic [4:0] c);
    return c[2] ? f_sel(c) : c[1];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1 <= 5'b10001; m2 <= 5'b10001;
      m_stb_d <= 1'b0; m_pend <= 1'b0; m_hold <= '0;
    end else begin
      m1 <= {sel_a_n, sel_b, mode, stb, clr_n};
      m2 <= m1;
      m_stb_d <= m2[1];
      if (f_lc(m2)) m_hold <= din;
      else if (!m2[0]) m_hold <= '0;
      if (f_sel(m2) || !m2[0]) m_pend <= 1'b0;
      else if (m_stb_d && !m2[1]) m_pend <= 1'b1;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_check();
    logic [W-1:0] e_d;
    e_d = f_lc(m2) ? din : m_hold;
    check(m2[2] ? "R2 oe" : "R3 oe", oe, m2[2] ? 1 : f_sel(m2));
    check(f_lc(m2) ? "R4 data" : "R5 data", dout, e_d);
    check("R8 irq", irq_n, !(m_pend || f_sel(m2)));
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      model_check();
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    din = 8'h77;
    repeat (3) @(negedge clk);
    check("R9 rst data", dout, 0);
    check("R9 rst irq", irq_n, 1);
    check("R9 rst oe", oe, 0);
    rst_n = 1'b1;
    step(4);
    check("R9 idle irq", irq_n, 1);
    check("R9 idle data", dout, 0);

    // R1: only sel_a low with sel_b high selects; latency two edges
    sel_a_n = 1'b0; sel_b = 1'b0; step(4);
    check("R1 half sel", oe, 0);
    sel_a_n = 1'b1; sel_b = 1'b1; step(4);
    check("R1 half sel b", oe, 0);
    sel_a_n = 1'b0;
    @(negedge clk); check("R1 lat1", oe, 0);
    @(negedge clk); check("R1 lat2", oe, 1); check("R8 sel irq", irq_n, 0);
    sel_a_n = 1'b1; sel_b = 1'b0; step(4);

    // R6: strobe fall raises irq after the third edge
    stb = 1'b1; step(4);
    stb = 1'b0;
    @(negedge clk); check("R6 e1", irq_n, 1);
    @(negedge clk); check("R6 e2", irq_n, 1);
    @(negedge clk); check("R6 e3", irq_n, 0);
    step(3); check("R6 stays", irq_n, 0);
    sel_a_n = 1'b0; sel_b = 1'b1; step(4);
    sel_a_n = 1'b1; sel_b = 1'b0; step(4);
    check("R7 sel drops", irq_n, 1);

    // R7: fall coinciding with select -> nothing pending
    stb = 1'b1; step(4);
    stb = 1'b0; sel_a_n = 1'b0; sel_b = 1'b1;
    @(negedge clk);
    sel_a_n = 1'b1; sel_b = 1'b0; step(5);
    check("R7 tie", irq_n, 1);
    stb = 1'b1; step(4);
    stb = 1'b0; clr_n = 1'b0; step(5);
    clr_n = 1'b1; step(3);
    check("R7 clr tie", irq_n, 1);

    // R5: clear ignored while transparent, applied while opaque
    mode = 1'b0; din = 8'h3c; stb = 1'b1; clr_n = 1'b0; step(5);
    check("R5 open", dout, 8'h3c);
    clr_n = 1'b1; step(4);
    stb = 1'b0; step(4);
    din = 8'hff; step(2);
    check("R5 kept", dout, 8'h3c);
    check("R4 held", dout, 8'h3c);
    clr_n = 1'b0; step(4);
    check("R5 zero", dout, 0);
    clr_n = 1'b1; step(2);

    // R2: mode high, select is the latch clock and output always on
    mode = 1'b1; din = 8'ha5; sel_a_n = 1'b0; sel_b = 1'b1; step(4);
    check("R2 open", dout, 8'ha5);
    sel_a_n = 1'b1; step(4);
    din = 8'h00; step(2);
    check("R2 held", dout, 8'ha5);
    check("R2 oe", oe, 1);
    mode = 1'b0; stb = 1'b0; step(4);
    check("R3 oe off", oe, 0);

    for (int i = 0; i < 4000; i++) begin
      din = W'($urandom);
      if ($urandom_range(3) == 0) stb = ~stb;
      if ($urandom_range(7) == 0) {sel_a_n, sel_b} = 2'($urandom);
      if ($urandom_range(15) == 0) mode = ~mode;
      clr_n = ($urandom_range(11) != 0);
      step(1);
    end
    summary();
  end
endmodule